// File: doc/BRIEF.md
# DSD Input Phase-Select Synchronizer

This block sits at the front of a multichannel DSD-to-PCM decimator. It takes six 1-bit DSD streams with their 64fs bit clock and brings them into the master-clock domain. It then hands one six-bit sample per DSD bit period to the decimation filter. Two capture registers are kept. The primary copy loads on the bit-clock rising edge, and the secondary copy takes the primary's contents on the following falling edge, half a bit period later. The filter therefore always reads from whichever copy is not moving at that moment.

The copy is picked on a resynchronisation, which starts when the init input is released or on a rising edge of sync. The first bit-clock falling edge after the event arms a phase flag that follows the bit-clock level. At the next word-boundary strobe, the flag's level fixes the choice. A high flag means the primary copy has just changed, so the secondary copy is used. A low flag selects the primary copy. A resync may drop or repeat one DSD sample. To hide that glitch, a mute request is raised at the event and released only after a number of word strobes that depends on the output rate.

Top module: `dsd_phase_sync`

## Requirements
- R1: While `initN` is low, `muteReq` is 1, `dsdValid` is 0 and `dsdOut` is all zeros.
- R2: Each `dsdValid` pulse presents the six bits that were on `dsdIn` at the most recent bit-clock rising edge that came at least half a bit period before the pulse, with channel i on bit i. `dsdOut` changes only on a `dsdValid` pulse.
- R3: After the arming falling edge, if `dsdBck` is high at the first `wordEdge` strobe, the secondary copy is selected and `dsdValid` pulses follow bit-clock rising edges. If it is low, the primary copy is selected and the pulses follow falling edges.
- R4: A rising edge on `syncIn`, or the release of `initN`, starts a resync. `muteReq` is 1 within four master-clock cycles, and holding `syncIn` high does not start another resync.
- R5: After the selecting `wordEdge` strobe, `muteReq` stays 1 through a further N strobes and drops one cycle after the Nth. N is 36 for `rateSel`=0 (4fs), 18 for `rateSel`=1 (2fs), and 10 for `rateSel`=2 or 3 (fs).
- R6: After `initN` is released, no `dsdValid` pulse appears until a selection has been made.
- R7: Once a selection is made, `dsdValid` is a single-cycle pulse that occurs exactly once per bit-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| initN | input | 1 | Active-low initialisation; release starts a resync |
| syncIn | input | 1 | Resync request, rising-edge sensitive, asynchronous |
| dsdBck | input | 1 | DSD 64fs bit clock, asynchronous |
| dsdIn | input | CH | DSD data, one bit per channel |
| wordEdge | input | 1 | One-cycle PCM word-boundary strobe in the `clk` domain |
| rateSel | input | 2 | Output rate: 0 = 4fs, 1 = 2fs, 2 or 3 = fs |
| dsdOut | output | CH | Selected DSD sample for the filter |
| dsdValid | output | 1 | One-cycle strobe when `dsdOut` holds a new sample |
| muteReq | output | 1 | Request to mute the PCM output after a resync |

## Verification
The bench builds the block with its default six channels and default mute counts. It uses a bit clock of 16 master-clock cycles and places word strobes either in the low half or the high half of the bit period, which covers both copy selections. It sweeps every rate code, both phases, and both init and sync as the starting event. Each data sample carries its own index, so the bench can compute exactly which sample each valid pulse must deliver.

// File: rtl/dsd_phase_sync_pkg.sv
package dsd_phase_sync_pkg;
  // Strobes from the resync control to the capture datapath
  typedef struct packed {
    logic armPhase;   // first bit-clock falling edge after a resync event
    logic latchSel;   // word boundary that fixes the copy selection
  } selStrobe_t;

  typedef enum logic [1:0] {
    ST_WAIT_FALL,
    ST_WAIT_WORD,
    ST_MUTE,
    ST_RUN
  } syncState_t;
endpackage

// File: rtl/dsd_capture_path.sv
module dsd_capture_path
  import dsd_phase_sync_pkg::*;
#(
  parameter int CH = 6
) (
  input  logic          clk,
  input  logic          initN,
  input  logic          dsdBck,
  input  logic [CH-1:0] dsdIn,
  input  selStrobe_t    strobe,
  output logic          bckRise,
  output logic          bckFall,
  output logic [CH-1:0] dsdOut,
  output logic          dsdValid
);
  logic          bckS1, bckS2, bckLast;
  logic [CH-1:0] dataS1, dataS2;
  logic [CH-1:0] bufA, bufB;
  logic          phaseFlag, selB, locked;
  logic          pickEdge;

  assign bckRise  = bckS2 & ~bckLast;
  assign bckFall  = ~bckS2 & bckLast;
  assign pickEdge = selB ? bckRise : bckFall;

  always_ff @(posedge clk or negedge initN) begin
    if (!initN) begin
      bckS1     <= 1'b0;
      bckS2     <= 1'b0;
      bckLast   <= 1'b0;
      dataS1    <= '0;
      dataS2    <= '0;
      bufA      <= '0;
      bufB      <= '0;
      phaseFlag <= 1'b0;
      selB      <= 1'b0;
      locked    <= 1'b0;
      dsdOut    <= '0;
      dsdValid  <= 1'b0;
    end else begin
      // two-stage synchronisers, data kept aligned with the clock
      bckS1   <= dsdBck;
      bckS2   <= bckS1;
      bckLast <= bckS2;
      dataS1  <= dsdIn;
      dataS2  <= dataS1;

      if (bckRise) bufA <= dataS2;
      if (bckFall) bufB <= bufA;

      // phase flag is realigned at the arming falling edge, then tracks the clock level
      if (strobe.armPhase)  phaseFlag <= 1'b0;
      else if (bckRise)     phaseFlag <= 1'b1;
      else if (bckFall)     phaseFlag <= 1'b0;

      if (strobe.latchSel) begin
        selB   <= phaseFlag;
        locked <= 1'b1;
      end

      dsdValid <= locked & pickEdge;
      if (locked && pickEdge) dsdOut <= selB ? bufB : bufA;
    end
  end
endmodule

// File: rtl/dsd_sync_ctl.sv
module dsd_sync_ctl
  import dsd_phase_sync_pkg::*;
#(
  parameter int MUTE_4X = 36,
  parameter int MUTE_2X = 18,
  parameter int MUTE_1X = 10
) (
  input  logic       clk,
  input  logic       initN,
  input  logic       syncIn,
  input  logic       bckFall,
  input  logic       wordEdge,
  input  logic [1:0] rateSel,
  output selStrobe_t strobe,
  output logic       syncRise,
  output logic       muteReq
);
  localparam int MAX_A = (MUTE_4X > MUTE_2X) ? MUTE_4X : MUTE_2X;
  localparam int MAX_M = (MAX_A > MUTE_1X) ? MAX_A : MUTE_1X;
  localparam int CNT_W = $clog2(MAX_M + 1);

  syncState_t       state;
  logic             syncS1, syncS2, syncLast;
  logic [CNT_W-1:0] muteCnt, muteLimit;

  assign syncRise = syncS2 & ~syncLast;
  assign muteReq  = (state != ST_RUN);

  always_comb begin
    strobe.armPhase = (state == ST_WAIT_FALL) && bckFall && !syncRise;
    strobe.latchSel = (state == ST_WAIT_WORD) && wordEdge && !syncRise;
  end

  always_comb begin
    unique case (rateSel)
      2'd0:    muteLimit = CNT_W'(MUTE_4X);
      2'd1:    muteLimit = CNT_W'(MUTE_2X);
      default: muteLimit = CNT_W'(MUTE_1X);
    endcase
  end

  always_ff @(posedge clk or negedge initN) begin
    if (!initN) begin
      syncS1   <= 1'b0;
      syncS2   <= 1'b0;
      syncLast <= 1'b0;
      state    <= ST_WAIT_FALL;
      muteCnt  <= '0;
    end else begin
      syncS1   <= syncIn;
      syncS2   <= syncS1;
      syncLast <= syncS2;
      if (syncRise) begin
        state <= ST_WAIT_FALL;
      end else begin
        unique case (state)
          ST_WAIT_FALL: if (bckFall) state <= ST_WAIT_WORD;
          ST_WAIT_WORD: if (wordEdge) begin
            state   <= ST_MUTE;
            muteCnt <= '0;
          end
          ST_MUTE: if (wordEdge) begin
            if (muteCnt == muteLimit - 1'b1) state <= ST_RUN;
            else muteCnt <= muteCnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsd_phase_sync.sv
module dsd_phase_sync
  import dsd_phase_sync_pkg::*;
#(
  parameter int CH      = 6,
  parameter int MUTE_4X = 36,
  parameter int MUTE_2X = 18,
  parameter int MUTE_1X = 10
) (
  input  logic          clk,
  input  logic          initN,
  input  logic          syncIn,
  input  logic          dsdBck,
  input  logic [CH-1:0] dsdIn,
  input  logic          wordEdge,
  input  logic [1:0]    rateSel,
  output logic [CH-1:0] dsdOut,
  output logic          dsdValid,
  output logic          muteReq
);
  selStrobe_t strobe;
  logic       bckRise, bckFall, syncRise;

  dsd_sync_ctl #(
    .MUTE_4X(MUTE_4X), .MUTE_2X(MUTE_2X), .MUTE_1X(MUTE_1X)
  ) u_ctl (
    .clk(clk), .initN(initN), .syncIn(syncIn), .bckFall(bckFall),
    .wordEdge(wordEdge), .rateSel(rateSel), .strobe(strobe),
    .syncRise(syncRise), .muteReq(muteReq)
  );

  dsd_capture_path #(.CH(CH)) u_path (
    .clk(clk), .initN(initN), .dsdBck(dsdBck), .dsdIn(dsdIn),
    .strobe(strobe), .bckRise(bckRise), .bckFall(bckFall),
    .dsdOut(dsdOut), .dsdValid(dsdValid)
  );
endmodule

// File: rtl/dsd_phase_sync_chk.sv
module dsd_phase_sync_chk #(
  parameter int CH = 6
) (
  input logic          clk,
  input logic          initN,
  input logic          dsdValid,
  input logic [CH-1:0] dsdOut,
  input logic          muteReq,
  input logic          wordEdge,
  input logic          syncRise,
  input logic          bckRise,
  input logic          bckFall
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!initN)
    dsdValid |=> !dsdValid); // R7

  AST_OUT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!initN)
    !$stable(dsdOut) |-> dsdValid); // R2

  AST_SYNC_RAISES_MUTE: assert property (@(posedge clk) disable iff (!initN)
    syncRise |=> muteReq); // R4

  AST_MUTE_FALLS_ON_WORD: assert property (@(posedge clk) disable iff (!initN)
    $fell(muteReq) |-> $past(wordEdge)); // R5

  AST_VALID_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!initN)
    dsdValid |-> $past(bckRise || bckFall)); // R3
endmodule

bind dsd_phase_sync dsd_phase_sync_chk #(.CH(CH)) u_chk (
  .clk(clk), .initN(initN), .dsdValid(dsdValid), .dsdOut(dsdOut),
  .muteReq(muteReq), .wordEdge(wordEdge), .syncRise(syncRise),
  .bckRise(bckRise), .bckFall(bckFall)
);

// File: tb/dsd_phase_sync_bench.sv
`timescale 1ns/1ps
module dsd_phase_sync_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CH         = 6;
  localparam int BCK_TICKS  = 16;

  logic          clk = 1'b0;
  logic          initN = 1'b0;
  logic          syncIn = 1'b0;
  logic          dsdBck = 1'b0;
  logic [CH-1:0] dsdIn = '0;
  logic          wordEdge = 1'b0;
  logic [1:0]    rateSel = 2'd0;
  logic [CH-1:0] dsdOut;
  logic          dsdValid;
  logic          muteReq;

  int checks = 0;
  int failures = 0;
  int tick = 0;
  int dataIdx = 0;
  int wordCount = 0;
  int wordPhase = 5;
  bit chkOn = 1'b0;
  bit noValidZone = 1'b0;
  bit zoneHit = 1'b0;
  bit expectHigh = 1'b0;
  int lastValid = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsd_phase_sync u_dsd_phase_sync (
    .clk(clk), .initN(initN), .syncIn(syncIn), .dsdBck(dsdBck), .dsdIn(dsdIn),
    .wordEdge(wordEdge), .rateSel(rateSel), .dsdOut(dsdOut),
    .dsdValid(dsdValid), .muteReq(muteReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  // stimulus generator: bit clock, data (changes on falling edges), word strobes
  always @(negedge clk) begin
    int t;
    tick++;
    t = tick % BCK_TICKS;
    dsdBck = (t >= BCK_TICKS/2);
    if (t == 0) begin
      dataIdx++;
      dsdIn = CH'(dataIdx);
    end
    wordEdge = (t == wordPhase) && (((tick / BCK_TICKS) % 2) == 0);
    if (wordEdge) wordCount++;
  end

  // output monitor, sampled well after the generator settles
  always @(negedge clk) begin
    #2;
    if (dsdValid && noValidZone) zoneHit = 1'b1;
    if (dsdValid && chkOn) begin
      check(dsdOut == CH'(dataIdx - 1), "R2 sample value", dsdOut, (dataIdx - 1) & 63);
      check(dsdBck == expectHigh, "R3 valid edge side", dsdBck, expectHigh);
      if (lastValid >= 0) check(tick - lastValid == BCK_TICKS, "R7 valid spacing",
                                tick - lastValid, BCK_TICKS);
      lastValid = tick;
    end
  end

  task automatic stepClk(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic waitPhase(input int ph);
    do stepClk(1); while ((tick % BCK_TICKS) != ph);
  endtask

  task automatic waitWords(input int target);
    while (wordCount < target) stepClk(1);
  endtask

  task automatic runResync(input int rate, input int phase, input bit useInit);
    int n, w0;
    n = (rate == 0) ? 36 : (rate == 1) ? 18 : 10;
    rateSel = 2'(rate);
    wordPhase = phase;
    waitPhase(BCK_TICKS - 3);
    if (useInit) begin
      initN = 1'b0;
      noValidZone = 1'b1;
      zoneHit = 1'b0;
      stepClk(2);
      check(muteReq == 1'b1, "R1 reset mute", muteReq, 1);
      check(dsdValid == 1'b0, "R1 reset valid", dsdValid, 0);
      check(dsdOut == '0, "R1 reset data", dsdOut, 0);
      waitPhase(2);
      initN = 1'b1;
    end else begin
      waitPhase(2);
      syncIn = 1'b1;
      stepClk(3);
      syncIn = 1'b0;
    end
    stepClk(1);
    check(muteReq == 1'b1, "R4 mute raised", muteReq, 1);
    waitPhase(0);
    stepClk(4);
    w0 = wordCount;
    if (useInit) begin
      check(zoneHit == 1'b0, "R6 no valid before selection", zoneHit, 0);
      noValidZone = 1'b0;
    end
    waitWords(w0 + n);
    stepClk(4);
    check(muteReq == 1'b1, "R5 mute still held", muteReq, 1);
    waitWords(w0 + 1 + n);
    stepClk(4);
    check(muteReq == 1'b0, "R5 mute released", muteReq, 0);
    expectHigh = (phase >= BCK_TICKS/2);
    lastValid = -1;
    chkOn = 1'b1;
    stepClk(6 * BCK_TICKS);
    chkOn = 1'b0;
  endtask

  initial begin
    stepClk(3);
    runResync(0, 5, 1'b1);
    runResync(0, 13, 1'b0);
    runResync(1, 5, 1'b0);
    runResync(1, 13, 1'b1);
    runResync(2, 13, 1'b0);
    runResync(3, 5, 1'b0);
    runResync(2, 5, 1'b1);
    // R4: sync held high must not restart the resync
    waitPhase(2);
    syncIn = 1'b1;
    stepClk(40 * BCK_TICKS);
    check(muteReq == 1'b0, "R4 level does not retrigger", muteReq, 0);
    syncIn = 1'b0;
    stepClk(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule